// File: doc/BRIEF.md
# Sequence Completion Interrupt Controller

This block raises the interrupt flags of a converter front end that runs two conversion sequences. Each sequence reports a conversion-done pulse for each result and a sequence-done pulse when its channel list is finished. A mode input per sequence picks what its flag reports. In per-conversion mode the flag follows the sequence's result-valid state. In per-sequence mode the flag latches the end of the sequence. Two more sources sit beside them: a threshold-violation flag set by an external pulse, and an overrun flag. The block raises the overrun flag when a new result lands on an unread one.

Every source has an enable bit. The single interrupt request is the OR of the enabled flags. Masking a source hides it from the request but leaves its flag as it is. Clearing depends on the source. A read strobe on the result register clears the result-valid state. A write-one-to-clear strobe or a DMA acknowledge clears a latched sequence flag. A write-one-to-clear strobe clears the threshold and overrun flags. When a set and a clear come in the same cycle, the set wins.

Each sequence has a four-state machine with the states EMPTY, VALID, DONE and BOTH. The state holds two bits: result-valid and sequence-latched. Four transitions act on it. Conversion arrival sets valid. Result read clears valid. Sequence end sets the latch, and only in per-sequence mode. Clear (write-one-to-clear or DMA acknowledge) drops the latch. The threshold and overrun flags each use a two-state machine, IDLE and PEND.

Top module: `seq_irq_ctrl`

## Requirements
- R1: After reset, and whenever reset is asserted, all flags, all result-valid outputs and `irq` are 0.
- R2: A `conv_done[i]` pulse makes `rslt_valid[i]` 1 at the next clock edge. In per-conversion mode (`seq_mode[i]`=0), flag bit i equals `rslt_valid[i]`. Flag bit i belongs to sequence i.
- R3: A `rd_result[i]` strobe clears `rslt_valid[i]` at the next edge. If `conv_done[i]` comes in the same cycle, valid stays 1.
- R4: In per-sequence mode (`seq_mode[i]`=1), a `seq_done[i]` pulse sets flag bit i. Conversion pulses and result reads do not change that flag.
- R5: In per-sequence mode, flag bit i is cleared by `w1c[i]` or by `dma_ack[i]`. A `seq_done[i]` in the same cycle keeps it set.
- R6: In per-conversion mode, `seq_done[i]`, `w1c[i]` and `dma_ack[i]` do not change flag bit i.
- R7: Flag bit N_SEQ is the threshold flag. `thr_evt` sets it, `w1c[N_SEQ]` clears it, and a set in the same cycle wins.
- R8: Flag bit N_SEQ+1 is the overrun flag. It is set when some `conv_done[i]` comes while `rslt_valid[i]` is 1 and `rd_result[i]` is 0. `w1c[N_SEQ+1]` clears it, and a set in the same cycle wins.
- R9: `irq` is 1 exactly when some flag bit and its `int_en` bit are both 1. Changing `int_en` never changes any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| seq_mode | input | N_SEQ | Per sequence: 0 = flag per conversion, 1 = flag per sequence |
| conv_done | input | N_SEQ | One-cycle pulse: a conversion result is written |
| seq_done | input | N_SEQ | One-cycle pulse: the sequence has finished |
| rd_result | input | N_SEQ | One-cycle strobe: the sequence's result register is read |
| w1c | input | N_SEQ+2 | Write-one-to-clear strobes, one per flag bit |
| dma_ack | input | N_SEQ | DMA acknowledge, clears the latched sequence flag |
| thr_evt | input | 1 | One-cycle pulse: threshold violation |
| int_en | input | N_SEQ+2 | Enable per flag bit |
| flags | output | N_SEQ+2 | Flags: [i] sequence i, [N_SEQ] threshold, [N_SEQ+1] overrun |
| rslt_valid | output | N_SEQ | Result-valid state per sequence |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default of two sequences. With this setting it can hold one sequence in per-conversion mode and the other in per-sequence mode at the same time, so the two clearing rules are checked in the same run. It then switches the second sequence to per-conversion mode on the fly, where its flag must take on the result-valid state. The overrun flag is driven from both sequences. This covers a read that falls on the same cycle as a new result, and a new overrun that falls on the same cycle as its own clear.

// File: rtl/irq_pkg.sv
package irq_pkg;

    // encoding: bit 1 = sequence latched, bit 0 = result valid
    typedef enum logic [1:0] {
        SQ_EMPTY = 2'b00,
        SQ_VALID = 2'b01,
        SQ_DONE  = 2'b10,
        SQ_BOTH  = 2'b11
    } seq_st_t;

    typedef enum logic {
        EV_IDLE = 1'b0,
        EV_PEND = 1'b1
    } evt_st_t;

    function automatic seq_st_t seq_pack(input logic latched, input logic valid);
        return seq_st_t'({latched, valid});
    endfunction

endpackage

// File: rtl/seq_flag_fsm.sv
module seq_flag_fsm
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode,
    input  logic conv_done,
    input  logic seq_done,
    input  logic rd_result,
    input  logic clr_req,
    output logic flag,
    output logic valid,
    output logic ovr_hit
);

    seq_st_t state;
    seq_st_t state_nxt;
    logic    latched;
    logic    set_latch;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SQ_EMPTY;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        set_latch = mode & seq_done;
        state_nxt = state;
        unique case (state)
            SQ_EMPTY: state_nxt = seq_pack(set_latch, conv_done);
            SQ_VALID: state_nxt = seq_pack(set_latch, conv_done | ~rd_result);
            SQ_DONE:  state_nxt = seq_pack(set_latch | ~clr_req, conv_done);
            SQ_BOTH:  state_nxt = seq_pack(set_latch | ~clr_req, conv_done | ~rd_result);
            default:  state_nxt = SQ_EMPTY;
        endcase
    end

    always_comb begin
        valid   = (state == SQ_VALID) || (state == SQ_BOTH);
        latched = (state == SQ_DONE) || (state == SQ_BOTH);
        flag    = mode ? latched : valid;
        ovr_hit = conv_done & valid & ~rd_result;
    end

    // R2
    conv_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> valid);

    // R3
    rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_result && !conv_done) |=> !valid);

    // R4
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && !clr_req) |=> latched);

    // R5
    latch_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !(mode && seq_done)) |=> !latched);

    // R6
    mode0_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode && !latched) |=> !latched);

endmodule

// File: rtl/evt_flag.sv
module evt_flag
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    output logic flag
);

    evt_st_t state;
    evt_st_t state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= EV_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            EV_IDLE: if (set_evt) state_nxt = EV_PEND;
            EV_PEND: if (clr_evt && !set_evt) state_nxt = EV_IDLE;
            default: state_nxt = EV_IDLE;
        endcase
    end

    always_comb begin
        flag = (state == EV_PEND);
    end

    // R7 R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);

    // R7 R8
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && !set_evt) |=> !flag);

endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
    parameter int N_SRC = 4
) (
    input  logic [N_SRC-1:0] flags,
    input  logic [N_SRC-1:0] en,
    output logic             irq
);

    logic [N_SRC-1:0] masked;

    for (genvar g = 0; g < N_SRC; g++) begin : g_mask
        assign masked[g] = flags[g] & en[g];
    end

    assign irq = |masked;

    // R9
    always_comb begin
        mask_off_chk: assert (!(en == '0 && irq));
    end

endmodule

// File: rtl/seq_irq_ctrl.sv
module seq_irq_ctrl #(
    parameter int N_SEQ = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SEQ-1:0] seq_mode,
    input  logic [N_SEQ-1:0] conv_done,
    input  logic [N_SEQ-1:0] seq_done,
    input  logic [N_SEQ-1:0] rd_result,
    input  logic [N_SEQ+1:0] w1c,
    input  logic [N_SEQ-1:0] dma_ack,
    input  logic             thr_evt,
    input  logic [N_SEQ+1:0] int_en,
    output logic [N_SEQ+1:0] flags,
    output logic [N_SEQ-1:0] rslt_valid,
    output logic             irq
);

    localparam int N_SRC   = N_SEQ + 2;
    localparam int THR_BIT = N_SEQ;
    localparam int OVR_BIT = N_SEQ + 1;

    logic [N_SEQ-1:0] seq_flag;
    logic [N_SEQ-1:0] ovr_hit;
    logic             thr_flag;
    logic             ovr_flag;

    for (genvar s = 0; s < N_SEQ; s++) begin : g_seq
        seq_flag_fsm u_seq (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode      (seq_mode[s]),
            .conv_done (conv_done[s]),
            .seq_done  (seq_done[s]),
            .rd_result (rd_result[s]),
            .clr_req   (w1c[s] | dma_ack[s]),
            .flag      (seq_flag[s]),
            .valid     (rslt_valid[s]),
            .ovr_hit   (ovr_hit[s])
        );
    end

    evt_flag u_thr (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (thr_evt),
        .clr_evt (w1c[THR_BIT]),
        .flag    (thr_flag)
    );

    evt_flag u_ovr (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (|ovr_hit),
        .clr_evt (w1c[OVR_BIT]),
        .flag    (ovr_flag)
    );

    assign flags = {ovr_flag, thr_flag, seq_flag};

    irq_combine #(.N_SRC(N_SRC)) u_comb (
        .flags (flags),
        .en    (int_en),
        .irq   (irq)
    );

    // R8
    ovr_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(conv_done & rslt_valid & ~rd_result)) |=> flags[OVR_BIT]);

    // R9
    en_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_en != $past(int_en) && conv_done == '0 && seq_done == '0 && rd_result == '0
         && w1c == '0 && dma_ack == '0 && !thr_evt && !$past(thr_evt)) |-> $stable(flags[N_SEQ]));

endmodule

// File: tb/tb_seq_irq_ctrl.sv
`timescale 1ns/100ps
module tb_seq_irq_ctrl;

    localparam int N_SEQ = 2;
    localparam int NV    = 21;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] seq_mode, conv_done, seq_done, rd_result, dma_ack, rslt_valid;
    logic [3:0] w1c, int_en, flags;
    logic       thr_evt, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    seq_irq_ctrl #(.N_SEQ(N_SEQ)) dut (
        .clk(clk), .rst_n(rst_n), .seq_mode(seq_mode), .conv_done(conv_done),
        .seq_done(seq_done), .rd_result(rd_result), .w1c(w1c), .dma_ack(dma_ack),
        .thr_evt(thr_evt), .int_en(int_en), .flags(flags), .rslt_valid(rslt_valid),
        .irq(irq)
    );

    // {mode, conv, seqd, rd, w1c, dma, thr, en, exp_flags, exp_valid, exp_irq}
    localparam logic [25:0] VEC [NV] = '{
        {2'b10,2'b01,2'b00,2'b00,4'b0000,2'b00,1'b0,4'b1111, 4'b0001,2'b01,1'b1}, // 0  R2
        {2'b10,2'b01,2'b00,2'b00,4'b0000,2'b00,1'b0,4'b1111, 4'b1001,2'b01,1'b1}, // 1  R8
        {2'b10,2'b01,2'b00,2'b01,4'b0000,2'b00,1'b0,4'b1111, 4'b1001,2'b01,1'b1}, // 2  R3
        {2'b10,2'b00,2'b00,2'b01,4'b0000,2'b00,1'b0,4'b1111, 4'b1000,2'b00,1'b1}, // 3  R3
        {2'b10,2'b00,2'b00,2'b00,4'b1000,2'b00,1'b0,4'b1111, 4'b0000,2'b00,1'b0}, // 4  R8
        {2'b10,2'b10,2'b00,2'b00,4'b0000,2'b00,1'b0,4'b1111, 4'b0000,2'b10,1'b0}, // 5  R4
        {2'b10,2'b00,2'b10,2'b00,4'b0000,2'b00,1'b0,4'b1111, 4'b0010,2'b10,1'b1}, // 6  R4
        {2'b10,2'b00,2'b00,2'b10,4'b0000,2'b00,1'b0,4'b1111, 4'b0010,2'b00,1'b1}, // 7  R4
        {2'b10,2'b00,2'b10,2'b00,4'b0010,2'b00,1'b0,4'b1111, 4'b0010,2'b00,1'b1}, // 8  R5
        {2'b10,2'b00,2'b00,2'b00,4'b0000,2'b10,1'b0,4'b1111, 4'b0000,2'b00,1'b0}, // 9  R5
        {2'b10,2'b00,2'b01,2'b00,4'b0001,2'b01,1'b0,4'b1111, 4'b0000,2'b00,1'b0}, // 10 R6
        {2'b10,2'b00,2'b00,2'b00,4'b0000,2'b00,1'b1,4'b1111, 4'b0100,2'b00,1'b1}, // 11 R7
        {2'b10,2'b00,2'b00,2'b00,4'b0100,2'b00,1'b1,4'b1111, 4'b0100,2'b00,1'b1}, // 12 R7
        {2'b10,2'b00,2'b00,2'b00,4'b0000,2'b00,1'b0,4'b1011, 4'b0100,2'b00,1'b0}, // 13 R9
        {2'b10,2'b00,2'b00,2'b00,4'b0000,2'b00,1'b0,4'b1111, 4'b0100,2'b00,1'b1}, // 14 R9
        {2'b10,2'b00,2'b00,2'b00,4'b0100,2'b00,1'b0,4'b1111, 4'b0000,2'b00,1'b0}, // 15 R7
        {2'b10,2'b11,2'b00,2'b00,4'b0000,2'b00,1'b0,4'b1111, 4'b0001,2'b11,1'b1}, // 16 R2
        {2'b10,2'b11,2'b00,2'b10,4'b0000,2'b00,1'b0,4'b1111, 4'b1001,2'b11,1'b1}, // 17 R8
        {2'b10,2'b10,2'b00,2'b00,4'b1000,2'b00,1'b0,4'b1111, 4'b1001,2'b11,1'b1}, // 18 R8
        {2'b00,2'b00,2'b00,2'b00,4'b0000,2'b00,1'b0,4'b1111, 4'b1011,2'b11,1'b1}, // 19 R2
        {2'b00,2'b00,2'b00,2'b11,4'b1000,2'b00,1'b0,4'b1111, 4'b0000,2'b00,1'b0}  // 20 R3
    };

    function automatic string row_tag(input int i);
        case (i)
            0, 16, 19:         return "R2";
            2, 3, 20:          return "R3";
            5, 6, 7:           return "R4";
            8, 9:              return "R5";
            10:                return "R6";
            11, 12, 15:        return "R7";
            1, 4, 17, 18:      return "R8";
            default:           return "R9";
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        conv_done = '0; seq_done = '0; rd_result = '0;
        w1c = '0; dma_ack = '0; thr_evt = 1'b0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; seq_mode = 2'b10; int_en = 4'hF;
        idle_inputs();
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1", "flags", 32'(flags), 32'h0);
        chk("R1", "valid", 32'(rslt_valid), 32'h0);
        chk("R1", "irq", 32'(irq), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {seq_mode, conv_done, seq_done, rd_result, w1c, dma_ack, thr_evt, int_en}
                = VEC[i][25:7];
            @(posedge clk);
            #1;
            chk(row_tag(i), $sformatf("row %0d flags", i), 32'(flags), 32'(VEC[i][6:3]));
            chk(row_tag(i), $sformatf("row %0d valid", i), 32'(rslt_valid), 32'(VEC[i][2:1]));
            chk(row_tag(i), $sformatf("row %0d irq", i), 32'(irq), 32'(VEC[i][0]));
        end

        // R9: all sources masked, flags kept
        @(negedge clk);
        idle_inputs(); seq_mode = 2'b00; int_en = 4'h0;
        thr_evt = 1'b1; conv_done = 2'b01;
        @(negedge clk);
        idle_inputs(); conv_done = 2'b01;
        @(negedge clk);
        idle_inputs();
        @(posedge clk);
        #1;
        chk("R9", "masked irq", 32'(irq), 32'h0);
        chk("R9", "masked flags", 32'(flags), 32'hD);
        @(negedge clk);
        int_en = 4'b1000;
        #1;
        chk("R9", "overrun only irq", 32'(irq), 32'h1);

        // R1 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1", "flags in reset", 32'(flags), 32'h0);
        chk("R1", "valid in reset", 32'(rslt_valid), 32'h0);
        chk("R1", "irq in reset", 32'(irq), 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule